// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave end of a two-wire serial bus in front of a small byte-wide non-volatile memory. It synchronises the clock and data lines and detects START and STOP conditions. It checks a fixed 7-bit device address and acknowledges the address and every byte it receives. A write transfer loads an internal word pointer and then a data byte. A read transfer streams bytes starting at the pointer for as long as the master acknowledges them.

The data line is open-drain. When `sda_oe_o` is high, the pad pulls the line low. The memory behind the block is a simple synchronous port: read data appears one clock after the address. A write is committed at the STOP that ends a write transfer. A timed programming interval follows, and the slave ignores the bus until it ends. `busy_o` is high for that whole interval.

Top module: `serial_eeprom_slave`

## Requirements
- R1: The first byte after a START is the device byte: seven address bits, MSB first, then a direction bit (0 = write, 1 = read). If the address equals 1010000, the slave pulls SDA low during the ninth clock. Otherwise it gives no acknowledge and ignores the bus until the next START or STOP.
- R2: In a write transfer the slave acknowledges every received byte. The first byte after the device byte loads the word pointer. The following byte is held as the pending write data.
- R3: A STOP that ends a write transfer with a complete data byte produces exactly one `mem_we_o` pulse of one cycle. That pulse carries the pointer and the last data byte, and it comes from the cycle in which the STOP was detected.
- R4: `busy_o` rises together with the write pulse and stays high for exactly PROG_CYCLES clock cycles. While it is high the slave never drives SDA and acknowledges nothing, its own address included.
- R5: A read sends the byte at the pointer, MSB first. The pointer advances by one after every byte sent, and it wraps from 255 to 0.
- R6: If the master does not acknowledge a read byte, the slave releases SDA. It then drives nothing until the next START or STOP.
- R7: A START or STOP aborts any transfer in progress. If a STOP arrives before a data byte is complete, nothing is written and `busy_o` stays low.
- R8: The slave changes its SDA drive only while the synchronised SCL is low. It holds the drive constant across every SCL high phase.
- R9: A committed write leaves the pointer unchanged. A read with no new word address (current-address read) returns the byte just written.
- R10: After reset, `sda_oe_o`, `mem_we_o` and `busy_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line from the pad |
| sda_i | input | 1 | Serial data line from the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| mem_we_o | output | 1 | One-cycle memory write strobe |
| mem_addr_o | output | PTR_W | Memory address (word pointer) |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one clock after the address |
| busy_o | output | 1 | Programming interval in progress |

## Verification
The bound checker watches four properties on every cycle. The first is the rule that the SDA drive changes only while SCL is low. The second is the silence of the slave during the programming interval. The third is the single-cycle write strobe tied to a detected STOP. The fourth is the exact length of the busy interval. The bench scenarios are the only way to show the other behaviours. These are address match and mismatch, pointer loading, the data read back, pointer wrap-around, release after a master NACK, and transfers aborted by START or STOP. The bench compares these against its own model of the memory.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_RX_ACK,
      PH_TX,
      PH_TX_ACK,
      PH_HOLD
   } phase_t;

   typedef enum logic [1:0] {
      RX_DEV,
      RX_WORD,
      RX_DATA
   } rx_kind_t;
endpackage

// File: rtl/seeprom_line_sync.sv
module seeprom_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("seeprom_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_d, sda_d;

   // Both lines pass through equal-length chains so that their relative timing is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_o      = scl_pipe[STAGES-1];
   assign sda_o      = sda_pipe[STAGES-1];
   assign scl_rise_o = scl_o & ~scl_d;
   assign scl_fall_o = ~scl_o & scl_d;
   assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
   assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/seeprom_prog_timer.sv
module seeprom_prog_timer #(
   parameter int CYCLES = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CNT_W = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("seeprom_prog_timer: CYCLES must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             remain <= '0;
      else if (start_i)       remain <= CNT_W'(CYCLES);
      else if (remain != '0)  remain <= remain - 1'b1;
   end

   assign busy_o = (remain != '0);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
   import seeprom_pkg::*;
#(
   parameter int         PTR_W       = 8,
   parameter logic [6:0] DEV_ADDR    = 7'b1010000,
   parameter int         PROG_CYCLES = 500,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic              mem_we_o,
   output logic [PTR_W-1:0]  mem_addr_o,
   output logic [BYTE_W-1:0] mem_wdata_o,
   input  logic [BYTE_W-1:0] mem_rdata_i,
   output logic              busy_o
);
   generate
      if (PTR_W < 1 || PTR_W > BYTE_W) begin : g_bad_ptr
         $error("serial_eeprom_slave: PTR_W must lie in 1..8");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic commit;

   seeprom_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_det), .stop_o(stop_det)
   );

   seeprom_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy_o)
   );

   phase_t               phase;
   rx_kind_t             kind;
   logic [BIT_CNT_W-1:0] bit_cnt;
   logic [BYTE_W-1:0]    shreg;
   logic [BYTE_W-1:0]    wbuf;
   logic [PTR_W-1:0]     ptr;
   logic                 rw_rd, wr_pend, m_ack;

   assign commit      = stop_det & wr_pend & ~busy_o;
   assign mem_addr_o  = ptr;
   assign mem_wdata_o = wbuf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_we_o <= 1'b0;
      else        mem_we_o <= commit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         kind     <= RX_DEV;
         bit_cnt  <= '0;
         shreg    <= '0;
         wbuf     <= '0;
         ptr      <= '0;
         rw_rd    <= 1'b0;
         wr_pend  <= 1'b0;
         m_ack    <= 1'b0;
         sda_oe_o <= 1'b0;
      end else if (busy_o) begin
         phase    <= PH_IDLE;
         wr_pend  <= 1'b0;
         sda_oe_o <= 1'b0;
      end else if (start_det) begin
         phase    <= PH_RX;
         kind     <= RX_DEV;
         bit_cnt  <= '0;
         wr_pend  <= 1'b0;
         sda_oe_o <= 1'b0;
      end else if (stop_det) begin
         phase    <= PH_IDLE;
         wr_pend  <= 1'b0;
         sda_oe_o <= 1'b0;
      end else begin
         unique case (phase)
            PH_RX: begin
               if (scl_rise && bit_cnt != BIT_CNT_W'(BYTE_W)) begin
                  shreg   <= {shreg[BYTE_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (scl_fall && bit_cnt == BIT_CNT_W'(BYTE_W)) begin
                  bit_cnt <= '0;
                  unique case (kind)
                     RX_DEV: begin
                        if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                           rw_rd    <= shreg[0];
                           sda_oe_o <= 1'b1;
                           phase    <= PH_RX_ACK;
                        end else begin
                           phase    <= PH_HOLD;
                        end
                     end
                     RX_WORD: begin
                        ptr      <= shreg[PTR_W-1:0];
                        sda_oe_o <= 1'b1;
                        phase    <= PH_RX_ACK;
                     end
                     default: begin
                        wbuf     <= shreg;
                        wr_pend  <= 1'b1;
                        sda_oe_o <= 1'b1;
                        phase    <= PH_RX_ACK;
                     end
                  endcase
               end
            end
            PH_RX_ACK: begin
               if (scl_fall) begin
                  if (kind == RX_DEV && rw_rd) begin
                     shreg    <= mem_rdata_i;
                     sda_oe_o <= ~mem_rdata_i[BYTE_W-1];
                     bit_cnt  <= '0;
                     phase    <= PH_TX;
                  end else begin
                     sda_oe_o <= 1'b0;
                     kind     <= (kind == RX_DEV) ? RX_WORD : RX_DATA;
                     phase    <= PH_RX;
                  end
               end
            end
            PH_TX: begin
               if (scl_fall) begin
                  if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                     sda_oe_o <= 1'b0;
                     ptr      <= ptr + 1'b1;
                     phase    <= PH_TX_ACK;
                  end else begin
                     shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                     sda_oe_o <= ~shreg[BYTE_W-2];
                     bit_cnt  <= bit_cnt + 1'b1;
                  end
               end
            end
            PH_TX_ACK: begin
               if (scl_rise) begin
                  m_ack <= ~sda_s;
               end else if (scl_fall) begin
                  if (m_ack) begin
                     shreg    <= mem_rdata_i;
                     sda_oe_o <= ~mem_rdata_i[BYTE_W-1];
                     bit_cnt  <= '0;
                     phase    <= PH_TX;
                  end else begin
                     phase    <= PH_HOLD;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/seeprom_checker.sv
module seeprom_checker #(
   parameter int PROG_CYCLES = 500
) (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic stop_det,
   input logic sda_oe_o,
   input logic mem_we_o,
   input logic busy_o
);
   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_run <= 0;
      else if (busy_o) busy_run <= busy_run + 1;
      else             busy_run <= 0;
   end

   AST_SDA_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s)); // R8
   AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sda_oe_o); // R4
   AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> !mem_we_o); // R3
   AST_WE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $past(stop_det)); // R3
   AST_WE_OPENS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (busy_o && !$past(busy_o))); // R4
   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_run == PROG_CYCLES)); // R4
endmodule

bind serial_eeprom_slave seeprom_checker #(.PROG_CYCLES(PROG_CYCLES)) u_seeprom_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
   .sda_oe_o(sda_oe_o), .mem_we_o(mem_we_o), .busy_o(busy_o)
);

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;
   localparam int PROG = 300;
   localparam int H    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_oe, mem_we, busy;
   logic [7:0] mem_addr, mem_wdata, mem_rdata;
   logic       sda_line;

   int n_chk = 0;
   int n_bad = 0;
   int unstable = 0;
   int busy_cnt = 0;
   int last_run = 0;

   logic [7:0] mem    [256];
   logic [7:0] golden [256];

   always #4 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   serial_eeprom_slave #(.PROG_CYCLES(PROG)) u_serial_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .busy_o(busy)
   );

   function automatic logic [7:0] seed_val(int a);
      return 8'((a * 37 + 5) & 255);
   endfunction

   initial for (int i = 0; i < 256; i++) begin
      mem[i] = seed_val(i);
      golden[i] = seed_val(i);
   end

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   always @(posedge clk) begin
      if (busy) busy_cnt <= busy_cnt + 1;
      else begin
         if (busy_cnt != 0) last_run <= busy_cnt;
         busy_cnt <= 0;
      end
   end

   task automatic report;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b0; tick(H);
      m_scl = 1'b0; tick(H);
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b1; tick(H);
   endtask

   task automatic send_bit(logic b);
      m_sda = b; tick(H);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0;
   endtask

   task automatic get_bit(output logic b);
      logic oe_mid;
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H / 2);
      b = sda_line;
      oe_mid = sda_oe;
      tick(H / 2);
      if (sda_oe !== oe_mid) unstable++;
      m_scl = 1'b0;
   endtask

   task automatic write_byte(logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic read_byte(logic give_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      send_bit(~give_ack);
   endtask

   task automatic wait_idle;
      while (busy) tick(1);
      tick(4);
   endtask

   task automatic do_write(logic [7:0] a, logic [7:0] d);
      logic ack;
      bus_start;
      write_byte(8'hA0, ack); chk("R1 device ack", ack, 1);
      write_byte(a, ack);     chk("R2 word ack", ack, 1);
      write_byte(d, ack);     chk("R2 data ack", ack, 1);
      bus_stop;
      chk("R3 busy after write stop", busy, 1);
      golden[a] = d;
   endtask

   task automatic rand_read_first(logic [7:0] a);
      logic ack;
      bus_start;
      write_byte(8'hA0, ack); chk("R1 device ack (dummy write)", ack, 1);
      write_byte(a, ack);     chk("R2 word ack (dummy write)", ack, 1);
      bus_start;
      write_byte(8'hA1, ack); chk("R1 device ack read", ack, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report;
   end

   initial begin
      logic       ack;
      logic [7:0] d;
      logic       b;
      int         ones;
      void'($urandom(32'h5EED));
      tick(5);
      rst_n = 1'b1;
      tick(5);
      // R10 reset state
      chk("R10 sda_oe reset", sda_oe, 0);
      chk("R10 mem_we reset", mem_we, 0);
      chk("R10 busy reset", busy, 0);

      // Byte write, then probe the slave while it is programming (R4)
      do_write(8'h3C, 8'hA5);
      bus_start;
      write_byte(8'hA0, ack); chk("R4 no ack while busy", ack, 0);
      bus_stop;
      wait_idle;
      chk("R4 busy length", last_run, PROG);
      chk("R3 memory written", mem[8'h3C], 8'hA5);

      // R9 current-address read returns byte just written
      bus_start;
      write_byte(8'hA1, ack); chk("R9 device ack", ack, 1);
      read_byte(1'b0, d);     chk("R9 current-address data", d, golden[8'h3C]);
      bus_stop;

      // R5 sequential read with wrap 254 -> 255 -> 0
      rand_read_first(8'hFE);
      read_byte(1'b1, d); chk("R5 read byte 254", d, golden[254]);
      read_byte(1'b1, d); chk("R5 read byte 255", d, golden[255]);
      read_byte(1'b0, d); chk("R5 wrap read byte 0", d, golden[0]);
      // R6 after NACK the slave drives nothing
      ones = 0;
      for (int i = 0; i < 9; i++) begin
         get_bit(b);
         if (b) ones++;
      end
      chk("R6 released after nack", ones, 9);
      bus_stop;
      chk("R8 drive stable in SCL high", unstable, 0);

      // R1 wrong device address: no ack, following byte ignored
      bus_start;
      write_byte(8'hA2, ack); chk("R1 mismatch nack", ack, 0);
      write_byte(8'h10, ack); chk("R1 ignored after mismatch", ack, 0);
      bus_stop;
      chk("R1 mismatch no busy", busy, 0);

      // R7 STOP before data byte completes: nothing written
      bus_start;
      write_byte(8'hA0, ack);
      write_byte(8'h10, ack);
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      bus_stop;
      chk("R7 abort no busy", busy, 0);
      chk("R7 abort no write", mem[8'h10], golden[8'h10]);
      // R7 START during a write restarts address reception
      bus_start;
      write_byte(8'hA0, ack);
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      bus_start;
      write_byte(8'hA0, ack); chk("R7 restart device ack", ack, 1);
      bus_stop;
      chk("R7 restart no busy", busy, 0);

      // Random writes followed by random reads
      for (int k = 0; k < 6; k++) begin
         logic [7:0] a, v;
         a = 8'($urandom);
         v = 8'($urandom);
         do_write(a, v);
         wait_idle;
         rand_read_first(a);
         read_byte(1'b0, d); chk("R2 random readback", d, v);
         bus_stop;
      end
      chk("R8 drive stable overall", unstable, 0);
      report;
   end
endmodule